// File: doc/BRIEF.md
# Pin-Driven DAC Step Counter

This block holds a 12-bit DAC code and lets a host move it with two plain pins, one for raising the code and one for lowering it, without going through the serial bus. Each pin first passes through a two-flop synchronizer and then through a deglitch filter. The filter takes a new level only after that level has been seen on a set number of consecutive clock samples. A falling edge of the filtered raise pin, while the lower pin is low, adds one to the selected field of the code. A falling edge of the filtered lower pin, while the raise pin is low, subtracts one from it.

A two-bit step mode chooses which field counts. The field can be the whole word, the top 10 bits or the top 8 bits, so one step moves the code by 1, 4 or 16. The bits below the field never change on a step. At its limits the field saturates instead of wrapping.

Stepping only happens while the serial select input is high (serial side idle) and the power-ready input is high. The register file can load a new code in parallel. An asynchronous clear forces the code to zero, but only while power-ready is high. The load is a plain strobe with no back-pressure: it always takes effect on the next clock edge, and it has priority over a step in the same cycle.

Top module: `dac_step_counter`

## Requirements
- R1: A filtered falling edge on `inc_pin` while the filtered `dec_pin` is low and not falling adds one unit to the code. A filtered falling edge on `dec_pin` while the filtered `inc_pin` is low and not falling subtracts one unit. A falling edge while the other pin is high changes nothing.
- R2: Pin edges change nothing unless `bus_sel_n` is 1 and `pwr_ready` is 1 in the cycle the edge is acted on.
- R3: `step_mode` selects the field that counts: 2'b00 counts the whole 12 bits (unit 1), 2'b01 counts bits [11:2] (unit 4), and 2'b10 counts bits [11:4] (unit 16).
- R4: A step never alters the code bits below the selected field. For example, in mode 2'b10 the code 12'h89E steps up to 12'h8AE.
- R5: In mode 2'b11, pin edges are ignored and the code holds.
- R6: An increment while the field is all ones, or a decrement while the field is all zeros, leaves the code unchanged. The field never wraps.
- R7: While `clr` is 1 and `pwr_ready` is 1, `dac_code` is 12'h000 at once, without waiting for a clock edge. While `pwr_ready` is 0, `clr` has no effect.
- R8: A pin level is accepted only after it has been held for FILT_LEN consecutive synchronized samples (default 4). A pulse of only 2 cycles causes no step.
- R9: `load_en` = 1 writes `load_data` into the code on the next clock edge, and it wins over a step in the same cycle.
- R10: After `rst_n` is released, the code is 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Asynchronous clear of the code, gated by `pwr_ready` |
| pwr_ready | input | 1 | High once power-up is complete; enables stepping and clear |
| bus_sel_n | input | 1 | Serial select, active low; stepping only while high |
| inc_pin | input | 1 | Raw raise pin, falling edge steps up |
| dec_pin | input | 1 | Raw lower pin, falling edge steps down |
| step_mode | input | 2 | Field select: 00 full, 01 upper 10, 10 upper 8, 11 reserved |
| load_en | input | 1 | Parallel load strobe from the register file |
| load_data | input | 12 | Code to load |
| dac_code | output | 12 | Current DAC register value |

## Verification
The hardest situations to reach are the edge cases on the pins: a pin that falls while the other pin is still held high, and a pulse shorter than the filter window. The stimulus drives both pins at the same time, so the raise pin falls while the lower pin is high. When the lower pin later falls alone, that one edge must decrement. Separate two-cycle glitches check that the filter drops them. Saturation is reached by loading codes whose selected field is already at all ones or all zeros. The asynchronous clear is sampled between clock edges to show it does not wait for one.

// File: rtl/dstep_pkg.sv
package dstep_pkg;
  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_TEN   = 2'b01,
    MODE_EIGHT = 2'b10,
    MODE_RSVD  = 2'b11
  } step_mode_e;
endpackage

// File: rtl/dstep_deglitch.sv
module dstep_deglitch #(
  parameter int SAMPLES = 4,
  localparam int CW = $clog2(SAMPLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic fall
);
  logic          s1_q, s2_q, prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      level  <= 1'b0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= level;
      if (s2_q != level) begin
        if (cnt_q == CW'(SAMPLES - 1)) begin
          level <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign fall = prev_q & ~level;

  // R8: the filtered level moves only after a full run of differing samples
  a_r8_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(cnt_q) == CW'(SAMPLES - 1)));
endmodule

// File: rtl/dstep_stepper.sv
module dstep_stepper
  import dstep_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] code,
  input  step_mode_e   mode,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] nxt,
  output logic [W-1:0] hi_mask,
  output logic         at_max,
  output logic         at_min
);
  logic [2:0]   shift;
  logic [W-1:0] unit;

  always_comb begin
    unique case (mode)
      MODE_TEN:   shift = 3'd2;
      MODE_EIGHT: shift = 3'd4;
      default:    shift = 3'd0;
    endcase
    unit    = W'(1) << shift;
    hi_mask = ~(unit - W'(1));
    at_max  = (code & hi_mask) == hi_mask;
    at_min  = (code & hi_mask) == '0;
    nxt     = code;
    if (inc && !at_max)      nxt = code + unit;
    else if (dec && !at_min) nxt = code - unit;
  end
endmodule

// File: rtl/dac_step_counter.sv
module dac_step_counter
  import dstep_pkg::*;
#(
  parameter int W        = 12,
  parameter int FILT_LEN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         pwr_ready,
  input  logic         bus_sel_n,
  input  logic         inc_pin,
  input  logic         dec_pin,
  input  logic [1:0]   step_mode,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] dac_code
);
  logic       inc_lvl, inc_fall, dec_lvl, dec_fall;
  logic       allow, inc_go, dec_go, at_max, at_min;
  logic       kill;
  logic [W-1:0] nxt, hi_mask;
  step_mode_e mode;

  assign mode = step_mode_e'(step_mode);
  assign kill = ~rst_n | (clr & pwr_ready);

  dstep_deglitch #(.SAMPLES(FILT_LEN)) u_inc_filt (
    .clk(clk), .rst_n(rst_n), .raw(inc_pin), .level(inc_lvl), .fall(inc_fall));
  dstep_deglitch #(.SAMPLES(FILT_LEN)) u_dec_filt (
    .clk(clk), .rst_n(rst_n), .raw(dec_pin), .level(dec_lvl), .fall(dec_fall));

  assign allow  = bus_sel_n & pwr_ready & (mode != MODE_RSVD);
  assign inc_go = allow & inc_fall & ~dec_lvl & ~dec_fall;
  assign dec_go = allow & dec_fall & ~inc_lvl & ~inc_fall;

  dstep_stepper #(.W(W)) u_step (
    .code(dac_code), .mode(mode), .inc(inc_go), .dec(dec_go),
    .nxt(nxt), .hi_mask(hi_mask), .at_max(at_max), .at_min(at_min));

  always_ff @(posedge clk or posedge kill) begin
    if (kill)         dac_code <= '0;
    else if (load_en) dac_code <= load_data;
    else              dac_code <= nxt;
  end

  // R2 / R5: with stepping blocked and no load the code holds
  a_r2_gated_hold: assert property (@(posedge clk) disable iff (kill)
    (!allow && !load_en) |=> $stable(dac_code));
  // R4: bits below the selected field are untouched by a step
  a_r4_low_kept: assert property (@(posedge clk) disable iff (kill)
    !load_en |=> ((dac_code & ~$past(hi_mask)) == ($past(dac_code) & ~$past(hi_mask))));
  // R6: no step past the top or bottom of the field
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (kill)
    (!load_en && inc_go && at_max) |=> $stable(dac_code));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (kill)
    (!load_en && dec_go && at_min) |=> $stable(dac_code));
  // R9: a load lands on the next edge
  a_r9_load: assert property (@(posedge clk) disable iff (kill)
    load_en |=> (dac_code == $past(load_data)));
  // R7: clear while ready forces zero
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && pwr_ready) |-> (dac_code == '0));
endmodule

// File: tb/dac_step_counter_bench.sv
module dac_step_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, clr = 1'b0, pwr_ready = 1'b1, bus_sel_n = 1'b1;
  logic        inc_pin = 1'b0, dec_pin = 1'b0, load_en = 1'b0;
  logic [1:0]  step_mode = 2'b00;
  logic [11:0] load_data = '0;
  logic [11:0] dac_code;

  typedef struct { logic [11:0] val; string tag; } exp_t;
  exp_t q[$];
  event chk_ev;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_step_counter u_dac_step_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pwr_ready(pwr_ready),
    .bus_sel_n(bus_sel_n), .inc_pin(inc_pin), .dec_pin(dec_pin),
    .step_mode(step_mode), .load_en(load_en), .load_data(load_data),
    .dac_code(dac_code));

  function automatic logic [11:0] model(logic [11:0] c, logic [1:0] m, bit up);
    int sh;
    logic [11:0] u, hm;
    sh = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 0;
    u  = 12'(1) << sh;
    hm = ~(u - 12'd1);
    if (up) return ((c & hm) == hm) ? c : c + u;
    return ((c & hm) == 0) ? c : c - u;
  endfunction

  // monitor: pops expected items and compares with the output
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (dac_code !== e.val) begin
        failures++;
        $display("FAIL %s: dac_code=%h expected=%h", e.tag, dac_code, e.val);
      end
    end
  end

  task automatic expect_now(logic [11:0] v, string tag);
    q.push_back('{v, tag});
    -> chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit up);
    if (up) inc_pin = 1'b1; else dec_pin = 1'b1;
    hold(HOLD);
    if (up) inc_pin = 1'b0; else dec_pin = 1'b0;
    hold(HOLD);
  endtask

  task automatic load(logic [11:0] v);
    load_data = v; load_en = 1'b1;
    hold(1);
    load_en = 1'b0;
    hold(1);
  endtask

  initial begin
    logic [11:0] cur;
    hold(3);
    rst_n = 1'b1;
    hold(2);
    expect_now(12'h000, "R10 reset value");

    load(12'h89E);
    expect_now(12'h89E, "R9 parallel load");
    step_mode = 2'b10;
    pulse(1);
    expect_now(12'h8AE, "R4 eight-bit step keeps low nibble");
    pulse(0);
    expect_now(12'h89E, "R1 decrement in eight-bit mode");
    step_mode = 2'b00;
    pulse(1);
    expect_now(12'h89F, "R3 full-word step of 1");
    step_mode = 2'b01;
    cur = model(12'h89F, 2'b01, 1);
    pulse(1);
    expect_now(cur, "R3 ten-bit step of 4");
    step_mode = 2'b11;
    pulse(1);
    expect_now(cur, "R5 reserved mode ignored");
    step_mode = 2'b00;
    bus_sel_n = 1'b0;
    pulse(1);
    expect_now(cur, "R2 serial select low blocks step");
    bus_sel_n = 1'b1;
    pwr_ready = 1'b0;
    pulse(0);
    expect_now(cur, "R2 not ready blocks step");
    clr = 1'b1;
    #1;
    expect_now(cur, "R7 clear ignored while not ready");
    hold(2);
    clr = 1'b0;
    pwr_ready = 1'b1;
    hold(2);

    // raise edge while lower pin held high: no step
    dec_pin = 1'b1; hold(HOLD);
    inc_pin = 1'b1; hold(HOLD);
    inc_pin = 1'b0; hold(HOLD);
    expect_now(cur, "R1 raise edge with lower pin high ignored");
    dec_pin = 1'b0; hold(HOLD);
    cur = model(cur, 2'b00, 0);
    expect_now(cur, "R1 lower edge alone decrements");

    // short glitches
    inc_pin = 1'b1; hold(2); inc_pin = 1'b0; hold(HOLD);
    expect_now(cur, "R8 two-cycle raise glitch dropped");
    dec_pin = 1'b1; hold(HOLD); dec_pin = 1'b0; hold(2);
    dec_pin = 1'b1; hold(HOLD);
    expect_now(cur, "R8 two-cycle low dip dropped");
    dec_pin = 1'b0; hold(HOLD);
    cur = model(cur, 2'b00, 0);
    expect_now(cur, "R8 accepted edge after dip");

    load(12'hFFF);
    pulse(1);
    expect_now(12'hFFF, "R6 full-word saturate at top");
    step_mode = 2'b10;
    load(12'h00F);
    pulse(0);
    expect_now(12'h00F, "R6 eight-bit saturate at bottom");
    load(12'hFF3);
    pulse(1);
    expect_now(12'hFF3, "R6 eight-bit saturate at top");

    // load wins over a step in the same cycle: make it land during step cycles
    step_mode = 2'b00;
    inc_pin = 1'b1; hold(HOLD); inc_pin = 1'b0;
    load_data = 12'h123; load_en = 1'b1;
    hold(HOLD);
    load_en = 1'b0; hold(HOLD);
    expect_now(12'h123, "R9 load has priority over step");

    // asynchronous clear between edges
    @(posedge clk); #2;
    clr = 1'b1;
    #1;
    expect_now(12'h000, "R7 clear acts without a clock edge");
    hold(2);
    clr = 1'b0;
    hold(2);
    pulse(1);
    expect_now(12'h001, "R1 stepping resumes after clear");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: dac_code=%h expected=finish", dac_code);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule